// File: doc/BRIEF.md
# Dual UART Baud Clock Selector

This block produces the bit-rate timing for two serial ports of a classic 8-bit microcontroller. It runs on the oscillator clock and takes overflow pulses from two timers. For each port it emits a transmit bit tick, a receive bit tick and a shift-clock tick for the synchronous mode. Every tick is a single-cycle enable pulse. The ports themselves, the timers and the frame logic live elsewhere and only consume these enables.

The block also holds the control bits that pick each port's rate. There is one serial control register per port, in which the top two bits set the mode and bit 5 is the fast-shift select. A shared rate register holds the per-port doublers, the per-direction timer choice for port 0 and the framing-error alias enable. The alias decides what bit 7 of both serial control registers means. A simple address/data port writes the registers and reads them back combinationally. A receiver pulses `fe_set` to raise a port's framing-error flag.

Top module: `dual_baud_sel`

## Requirements
- R1: Address 0 is port 0 serial control and address 1 is port 1. The mode is {bit7, bit6}, and bit 5 selects the fast shift rate. In mode 0 a port's ticks repeat every 12 oscillator cycles when bit 5 is 0 and every 4 cycles when it is 1. All registers reset to zero, so both ports start in mode 0 at the 12-cycle rate.
- R2: `sh_tick` pulses only in mode 0, and at the same period as that port's `tx_tick` and `rx_tick`. In modes 1 to 3 `sh_tick` stays low.
- R3: In mode 2 the ticks repeat every 64 oscillator cycles, or every 32 cycles when the port's doubler is set.
- R4: In modes 1 and 3 with Timer 1 as the source, a tick comes once per 32 `t1_ovf` pulses, or once per 16 pulses when the port's doubler is set.
- R5: The rate register sits at address 2 with dbl0 at bit 0, dbl1 at bit 1, fe_alias at bit 2, rx0_t2 at bit 3 and tx0_t2 at bit 4. In modes 1 and 3, rx0_t2 moves port 0 reception to `t2_ovf` and tx0_t2 moves port 0 transmission to `t2_ovf`, each on its own. A Timer 2 source gives one tick per 16 pulses whether or not the doubler is set.
- R6: The doubler has no effect on the mode 0 rate.
- R7: dbl0 changes only port 0 rates and dbl1 changes only port 1 rates.
- R8: Port 1 always counts `t1_ovf` in modes 1 and 3, whatever the state of rx0_t2 and tx0_t2, so its transmit and receive ticks are identical.
- R9: When fe_alias is 1, bit 7 of each serial control register reads and writes that port's framing-error flag, and the stored mode bit is kept. When fe_alias is 0, bit 7 reads and writes the mode bit. `fe_set[p]` sets the flag of port p only.
- R10: A change of a port's mode restarts its dividers. The first tick then appears exactly N+1 cycles after the clock edge that wrote the new mode, where N is the new oscillator divide. No tick appears in the cycle after the restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low synchronous reset |
| t1_ovf | input | 1 | Timer 1 overflow pulse |
| t2_ovf | input | 1 | Timer 2 overflow pulse |
| fe_set | input | 2 | Framing-error set pulse per port |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address for read and write |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register read data (combinational) |
| tx_tick | output | 2 | Transmit bit tick per port |
| rx_tick | output | 2 | Receive bit tick per port |
| sh_tick | output | 2 | Mode 0 shift-clock tick per port |

## Verification
Register reads are combinational, so each is sampled 1 ns after the address changes. Every tick leaves a register one edge after its counting event. The bench therefore measures rates as the spacing between two ticks sampled on falling edges, which does not depend on the phase of the divider when the configuration changed. The restart case counts falling edges from the write edge and expects the first tick at N+1. The extra cycle covers the registered mode and the registered tick. Framing-error set pulses and writes are visible on the next read after the edge that captured them.

// File: rtl/dual_baud_pkg.sv
package dual_baud_pkg;
    localparam int REG_W  = 8;
    localparam int ADDR_W = 2;
    localparam int NPORT  = 2;

    localparam logic [ADDR_W-1:0] ADDR_CFG = 2'd2;

    localparam logic [1:0] MODE_SHIFT = 2'd0;
    localparam logic [1:0] MODE_FIX9  = 2'd2;

    // bit positions inside the rate register
    localparam int B_DBL0  = 0;
    localparam int B_DBL1  = 1;
    localparam int B_FEAL  = 2;
    localparam int B_RX0T2 = 3;
    localparam int B_TX0T2 = 4;

    typedef struct packed {
        logic tx0_t2;
        logic rx0_t2;
        logic fe_alias;
        logic dbl1;
        logic dbl0;
    } rate_cfg_t;

    typedef struct packed {
        logic       sm0;
        logic       sm1;
        logic       fast;
        logic [4:0] low;
        logic       fe;
    } port_ctl_t;
endpackage

// File: rtl/dual_baud_regs.sv
module dual_baud_regs
    import dual_baud_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NPORT-1:0]        fe_set,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [REG_W-1:0]        wr_data,
    output logic [REG_W-1:0]        rd_data,
    output logic [NPORT-1:0][1:0]   mode,
    output logic [NPORT-1:0]        fast,
    output rate_cfg_t               cfg
);
    typedef struct packed {
        port_ctl_t [NPORT-1:0] pc;
        rate_cfg_t             cfg;
    } reg_st_t;

    reg_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            for (int p = 0; p < NPORT; p++) begin
                if (addr == ADDR_W'(p)) begin
                    st_d.pc[p].sm1  = wr_data[6];
                    st_d.pc[p].fast = wr_data[5];
                    st_d.pc[p].low  = wr_data[4:0];
                    if (st_q.cfg.fe_alias) st_d.pc[p].fe  = wr_data[7];
                    else                   st_d.pc[p].sm0 = wr_data[7];
                end
            end
            if (addr == ADDR_CFG) begin
                st_d.cfg.dbl0     = wr_data[B_DBL0];
                st_d.cfg.dbl1     = wr_data[B_DBL1];
                st_d.cfg.fe_alias = wr_data[B_FEAL];
                st_d.cfg.rx0_t2   = wr_data[B_RX0T2];
                st_d.cfg.tx0_t2   = wr_data[B_TX0T2];
            end
        end
        // a receiver report wins over a same-cycle write
        for (int p = 0; p < NPORT; p++) begin
            if (fe_set[p]) st_d.pc[p].fe = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        rd_data = '0;
        if (addr < ADDR_W'(NPORT)) begin
            rd_data = {st_q.cfg.fe_alias ? st_q.pc[addr[0]].fe : st_q.pc[addr[0]].sm0,
                       st_q.pc[addr[0]].sm1, st_q.pc[addr[0]].fast, st_q.pc[addr[0]].low};
        end else if (addr == ADDR_CFG) begin
            rd_data[B_DBL0]  = st_q.cfg.dbl0;
            rd_data[B_DBL1]  = st_q.cfg.dbl1;
            rd_data[B_FEAL]  = st_q.cfg.fe_alias;
            rd_data[B_RX0T2] = st_q.cfg.rx0_t2;
            rd_data[B_TX0T2] = st_q.cfg.tx0_t2;
        end
    end

    always_comb begin
        for (int p = 0; p < NPORT; p++) begin
            mode[p] = {st_q.pc[p].sm0, st_q.pc[p].sm1};
            fast[p] = st_q.pc[p].fast;
        end
        cfg = st_q.cfg;
    end
endmodule

// File: rtl/dual_baud_tickgen.sv
module dual_baud_tickgen
    import dual_baud_pkg::*;
#(
    parameter int CW          = 6,
    parameter int DIV_SH_SLOW = 12,
    parameter int DIV_SH_FAST = 4,
    parameter int DIV_FIX     = 64,
    parameter int DIV_T1      = 32,
    parameter int DIV_T2      = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       restart,
    input  logic [1:0] mode,
    input  logic       fast,
    input  logic       dbl,
    input  logic       use_t2,
    input  logic       t1_ovf,
    input  logic       t2_ovf,
    output logic       bit_tick,
    output logic       shift_tick
);
    localparam logic [CW-1:0] LIM_SH_SLOW = CW'(DIV_SH_SLOW - 1);
    localparam logic [CW-1:0] LIM_SH_FAST = CW'(DIV_SH_FAST - 1);
    localparam logic [CW-1:0] LIM_FIX     = CW'(DIV_FIX - 1);
    localparam logic [CW-1:0] LIM_FIX_DBL = CW'(DIV_FIX / 2 - 1);
    localparam logic [CW-1:0] LIM_T1      = CW'(DIV_T1 - 1);
    localparam logic [CW-1:0] LIM_T1_DBL  = CW'(DIV_T1 / 2 - 1);
    localparam logic [CW-1:0] LIM_T2      = CW'(DIV_T2 - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          tick;
        logic          sh;
    } tg_st_t;

    tg_st_t        st_d, st_q;
    logic [CW-1:0] lim;
    logic          osc_src;
    logic          ev;

    always_comb begin
        osc_src = (mode == MODE_SHIFT) || (mode == MODE_FIX9);
        if (mode == MODE_SHIFT)     lim = fast ? LIM_SH_FAST : LIM_SH_SLOW;
        else if (mode == MODE_FIX9) lim = dbl ? LIM_FIX_DBL : LIM_FIX;
        else if (use_t2)            lim = LIM_T2;
        else                        lim = dbl ? LIM_T1_DBL : LIM_T1;
        ev = osc_src ? 1'b1 : (use_t2 ? t2_ovf : t1_ovf);

        st_d      = st_q;
        st_d.tick = 1'b0;
        st_d.sh   = 1'b0;
        if (restart) begin
            st_d.cnt = '0;
        end else if (ev) begin
            if (st_q.cnt >= lim) begin
                st_d.cnt  = '0;
                st_d.tick = 1'b1;
                st_d.sh   = (mode == MODE_SHIFT);
            end else begin
                st_d.cnt  = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bit_tick   = st_q.tick;
    assign shift_tick = st_q.sh;
endmodule

// File: rtl/dual_baud_sel.sv
module dual_baud_sel
    import dual_baud_pkg::*;
#(
    parameter int CW          = 6,
    parameter int DIV_SH_SLOW = 12,
    parameter int DIV_SH_FAST = 4,
    parameter int DIV_FIX     = 64,
    parameter int DIV_T1      = 32,
    parameter int DIV_T2      = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              t1_ovf,
    input  logic              t2_ovf,
    input  logic [1:0]        fe_set,
    input  logic              wr_en,
    input  logic [1:0]        addr,
    input  logic [7:0]        wr_data,
    output logic [7:0]        rd_data,
    output logic [1:0]        tx_tick,
    output logic [1:0]        rx_tick,
    output logic [1:0]        sh_tick
);
    logic [NPORT-1:0][1:0] port_mode;
    logic [NPORT-1:0]      port_fast;
    rate_cfg_t             cfg;
    logic [NPORT-1:0]      restart;

    typedef struct packed {
        logic [NPORT-1:0][1:0] mode_prev;
    } top_st_t;

    top_st_t st_d, st_q;

    dual_baud_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .fe_set  (fe_set),
        .wr_en   (wr_en),
        .addr    (addr),
        .wr_data (wr_data),
        .rd_data (rd_data),
        .mode    (port_mode),
        .fast    (port_fast),
        .cfg     (cfg)
    );

    always_comb begin
        st_d = st_q;
        for (int p = 0; p < NPORT; p++) begin
            restart[p]      = (port_mode[p] != st_q.mode_prev[p]);
            st_d.mode_prev[p] = port_mode[p];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // dir 0 = transmit, dir 1 = receive
    for (genvar gp = 0; gp < NPORT; gp++) begin : g_port
        logic [1:0] bt, stk;
        logic       dbl;
        assign dbl = (gp == 0) ? cfg.dbl0 : cfg.dbl1;
        for (genvar gd = 0; gd < 2; gd++) begin : g_dir
            logic use_t2;
            if (gp == 0) begin : g_sel
                assign use_t2 = (gd == 0) ? cfg.tx0_t2 : cfg.rx0_t2;
            end else begin : g_fix
                assign use_t2 = 1'b0;
            end
            dual_baud_tickgen #(
                .CW(CW), .DIV_SH_SLOW(DIV_SH_SLOW), .DIV_SH_FAST(DIV_SH_FAST),
                .DIV_FIX(DIV_FIX), .DIV_T1(DIV_T1), .DIV_T2(DIV_T2)
            ) u_gen (
                .clk        (clk),
                .rst_n      (rst_n),
                .restart    (restart[gp]),
                .mode       (port_mode[gp]),
                .fast       (port_fast[gp]),
                .dbl        (dbl),
                .use_t2     (use_t2),
                .t1_ovf     (t1_ovf),
                .t2_ovf     (t2_ovf),
                .bit_tick   (bt[gd]),
                .shift_tick (stk[gd])
            );
        end
        assign tx_tick[gp] = bt[0];
        assign rx_tick[gp] = bt[1];
        assign sh_tick[gp] = stk[0] & stk[1];
    end
endmodule

// File: rtl/dual_baud_chk.sv
module dual_baud_chk (
    input logic            clk,
    input logic            rst_n,
    input logic            t1_ovf,
    input logic [1:0]      tx_tick,
    input logic [1:0]      rx_tick,
    input logic [1:0]      sh_tick,
    input logic [1:0][1:0] port_mode,
    input logic [1:0]      restart
);
    a_r2_sh_only_mode0_p0: assert property (@(posedge clk) disable iff (!rst_n)
        sh_tick[0] |-> $past(port_mode[0]) == 2'd0);

    a_r2_sh_only_mode0_p1: assert property (@(posedge clk) disable iff (!rst_n)
        sh_tick[1] |-> $past(port_mode[1]) == 2'd0);

    a_r1_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        tx_tick[0] |=> !tx_tick[0]);

    a_r8_p1_dirs_equal: assert property (@(posedge clk) disable iff (!rst_n)
        tx_tick[1] == rx_tick[1]);

    a_r8_p1_t1_only: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_tick[1] && ($past(port_mode[1]) == 2'd1 || $past(port_mode[1]) == 2'd3))
        |-> $past(t1_ovf));

    a_r10_restart_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        restart[0] |=> (!tx_tick[0] && !rx_tick[0]));
endmodule

bind dual_baud_sel dual_baud_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .t1_ovf    (t1_ovf),
    .tx_tick   (tx_tick),
    .rx_tick   (rx_tick),
    .sh_tick   (sh_tick),
    .port_mode (port_mode),
    .restart   (restart)
);

// File: tb/sim_dual_baud_sel.sv
`timescale 1ns/1ps
module sim_dual_baud_sel;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       t1_ovf, t2_ovf;
    logic [1:0] fe_set;
    logic       wr_en;
    logic [1:0] addr;
    logic [7:0] wr_data;
    logic [7:0] rd_data;
    logic [1:0] tx_tick, rx_tick, sh_tick;

    int n_cmp = 0;
    int n_bad = 0;
    int t1_per = 3;
    int t2_per = 5;
    bit done = 0;

    always #2.5 clk = ~clk;

    dual_baud_sel u0 (
        .clk(clk), .rst_n(rst_n), .t1_ovf(t1_ovf), .t2_ovf(t2_ovf),
        .fe_set(fe_set), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
        .rd_data(rd_data), .tx_tick(tx_tick), .rx_tick(rx_tick), .sh_tick(sh_tick)
    );

    logic [5:0] tk;
    assign tk = {sh_tick[1], rx_tick[1], tx_tick[1], sh_tick[0], rx_tick[0], tx_tick[0]};

    // timer overflow pulse sources
    initial begin
        int c1 = 0;
        int c2 = 0;
        t1_ovf = 1'b0;
        t2_ovf = 1'b0;
        forever begin
            @(negedge clk);
            c1++;
            c2++;
            t1_ovf = (t1_per != 0) && (c1 % t1_per == 0);
            t2_ovf = (t2_per != 0) && (c2 % t2_per == 0);
        end
    end

    // cfg, port0 ctl, port1 ctl, then periods of tx0 rx0 sh0 tx1 rx1 sh1
    localparam logic [71:0] VEC [9] = '{
        {8'h00, 8'h00, 8'h20, 8'd12, 8'd12, 8'd12, 8'd4,  8'd4,  8'd4 },
        {8'h03, 8'h20, 8'h00, 8'd4,  8'd4,  8'd4,  8'd12, 8'd12, 8'd12},
        {8'h00, 8'h80, 8'h80, 8'd64, 8'd64, 8'd0,  8'd64, 8'd64, 8'd0 },
        {8'h01, 8'h80, 8'h80, 8'd32, 8'd32, 8'd0,  8'd64, 8'd64, 8'd0 },
        {8'h00, 8'h40, 8'hC0, 8'd96, 8'd96, 8'd0,  8'd96, 8'd96, 8'd0 },
        {8'h02, 8'h40, 8'h40, 8'd96, 8'd96, 8'd0,  8'd48, 8'd48, 8'd0 },
        {8'h08, 8'h40, 8'h40, 8'd96, 8'd80, 8'd0,  8'd96, 8'd96, 8'd0 },
        {8'h11, 8'hC0, 8'h40, 8'd80, 8'd48, 8'd0,  8'd96, 8'd96, 8'd0 },
        {8'h1A, 8'h40, 8'hC0, 8'd80, 8'd80, 8'd0,  8'd48, 8'd48, 8'd0 }
    };

    function automatic string vec_tag(input int i);
        case (i)
            0: return "R1 R2";
            1: return "R6 R1";
            2: return "R3 R2";
            3: return "R3 R7";
            4: return "R4";
            5: return "R4 R7";
            6: return "R5";
            7: return "R5 R8";
            default: return "R5 R8 R7";
        endcase
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic reg_rd(input logic [1:0] a, output int v);
        @(negedge clk);
        addr = a;
        #1 v = int'(rd_data);
    endtask

    // spacing between two consecutive ticks of one output, 0 if none
    task automatic measure(input int idx, output int per);
        int n = 0;
        per = 0;
        while (!tk[idx] && n < 300) begin @(negedge clk); n++; end
        if (!tk[idx]) return;
        n = 0;
        do begin @(negedge clk); n++; end while (!tk[idx] && n < 300);
        if (tk[idx]) per = n;
    endtask

    task automatic first_tick(output int n);
        n = 0;
        do begin @(negedge clk); n++; end while (!tk[0] && n < 200);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(5ns * 150000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int v, per;
        rst_n = 1'b0; fe_set = 2'b00; wr_en = 1'b0; addr = 2'd0; wr_data = 8'h00;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // reset state (R1)
        for (int a = 0; a < 3; a++) begin
            reg_rd(2'(a), v);
            check("R1 reset register", v, 0);
        end
        measure(2, per); check("R1 reset shift rate p0", per, 12);
        measure(5, per); check("R1 reset shift rate p1", per, 12);

        // table of rate configurations
        for (int i = 0; i < 9; i++) begin
            reg_wr(2'd2, VEC[i][71:64]);
            reg_wr(2'd0, VEC[i][63:56]);
            reg_wr(2'd1, VEC[i][55:48]);
            for (int k = 0; k < 6; k++) begin
                measure(k, per);
                check($sformatf("%s vec %0d out %0d", vec_tag(i), i, k),
                      per, int'(VEC[i][47 - 8*k -: 8]));
            end
        end

        // framing-error alias (R9)
        reg_wr(2'd2, 8'h00);
        reg_wr(2'd0, 8'h40);
        reg_wr(2'd1, 8'h40);
        reg_wr(2'd2, 8'h04);
        reg_rd(2'd0, v); check("R9 alias flag clear", v, 8'h40);
        @(negedge clk); fe_set = 2'b01;
        @(negedge clk); fe_set = 2'b00;
        reg_rd(2'd0, v); check("R9 flag set p0", v, 8'hC0);
        reg_rd(2'd1, v); check("R9 flag p1 untouched", v, 8'h40);
        reg_wr(2'd2, 8'h00);
        reg_rd(2'd0, v); check("R9 mode bit kept", v, 8'h40);
        measure(0, per); check("R9 p0 still mode1", per, 96);
        reg_wr(2'd2, 8'h04);
        reg_wr(2'd0, 8'h40);
        reg_rd(2'd0, v); check("R9 flag cleared by write", v, 8'h40);
        reg_wr(2'd0, 8'hC0);
        reg_wr(2'd2, 8'h00);
        reg_rd(2'd0, v); check("R9 write leaves mode bit", v, 8'h40);
        reg_wr(2'd0, 8'h80);
        reg_rd(2'd0, v); check("R9 bit7 is mode bit", v, 8'h80);
        measure(0, per); check("R9 mode2 via bit7", per, 64);

        // restart on mode change (R10)
        t1_per = 0; t2_per = 0;
        reg_wr(2'd2, 8'h01);
        reg_wr(2'd0, 8'h40);
        repeat (5) @(negedge clk);
        reg_wr(2'd0, 8'h80);
        first_tick(v); check("R10 first tick mode2 dbl", v, 33);
        repeat (10) @(negedge clk);
        reg_wr(2'd0, 8'h20);
        first_tick(v); check("R10 first tick mode0 fast", v, 5);

        finish_run();
    end
endmodule